// File: doc/BRIEF.md
# Vector Register Group Micro-op Sequencer

This block takes one decoded vector arithmetic instruction and splits it into a run of single-register micro-ops, one for each register of the widest operand group. The instruction carries a destination index, a wide-capable first source (srcA), a narrow second source (srcB), a widening flag and the 3-bit length-multiplier code from the vector type configuration. The sequencer decodes the group size from the code. It checks that every operand group starts on an index that is a multiple of its group size, and it rejects reserved or oversized configurations.

A legal instruction is accepted over a valid/ready handshake. Micro-ops then leave in order over a second valid/ready handshake, each carrying the three register indices for its step. In a widening instruction the destination and srcA groups are twice the multiplier, and srcB advances only once per two steps, with a half-select bit naming the lower or upper half of the narrow register. An illegal instruction is refused with a one-cycle flag and produces nothing else.

Top module: `vrgSeq`

## Requirements
- R1: Multiplier codes 000, 001, 010 and 011 give group sizes 1, 2, 4 and 8, and a legal non-widening instruction issues that many micro-ops.
- R2: Codes 101, 110 and 111 (fractional multipliers) give a group size of one register for every operand, widening or not, so exactly one micro-op issues with half-select 0.
- R3: The destination and srcA indices must be multiples of the effective (wide) group size and srcB a multiple of the narrow group size; otherwise the instruction is illegal.
- R4: The first micro-op carries the base indices, and every later micro-op raises the destination, srcA and srcB indices by one (non-widening).
- R5: With the widening flag set and an integral multiplier of size L, 2*L micro-ops issue; destination and srcA rise by one per step, srcB rises by one every second step, and uopHalf equals bit 0 of the step number (0 = lower half, 1 = upper half).
- R6: A widening instruction with code 011 is illegal, since its wide groups would exceed 8 registers.
- R7: Code 100 is reserved and always illegal.
- R8: inReady is high only while no instruction is in flight; it drops from acceptance until the cycle after the micro-op carrying uopLast has been handed off, and inValid in that window has no effect.
- R9: An illegal instruction raises illegal combinationally in the accept cycle only, is consumed, and issues no micro-op.
- R10: A synchronous active-high reset returns the block to idle: uopValid 0, inReady 1, illegal 0, even in the middle of a sequence.
- R11: While uopValid is high and uopReady low, all micro-op outputs hold steady and the step does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Sequencer idle and able to accept |
| inDst | input | 5 | Destination group base index |
| inSrcA | input | 5 | First (wide-capable) source base index |
| inSrcB | input | 5 | Second (narrow) source base index |
| inWiden | input | 1 | Widening operation |
| inMulCode | input | 3 | Length-multiplier code |
| illegal | output | 1 | Instruction refused (accept cycle only) |
| uopValid | output | 1 | Micro-op offered |
| uopReady | input | 1 | Micro-op taken |
| uopDst | output | 5 | Micro-op destination index |
| uopSrcA | output | 5 | Micro-op first source index |
| uopSrcB | output | 5 | Micro-op second source index |
| uopHalf | output | 1 | Narrow source half-select |
| uopLast | output | 1 | Final micro-op of the instruction |

## Verification
The illegal flag is combinational, so the bench samples it one time unit after it drives the instruction, before the accepting edge. The first micro-op appears after exactly one register stage, so it is sampled at the falling edge that follows the accept edge. The bench then steps its own expected index only on edges where it had driven uopReady high. Stalled cycles therefore re-check the same expected values, and the idle state is checked at the falling edge after the last handoff.

// File: rtl/vrgPkg.sv
package vrgPkg;
  // Strobes sent from control to datapath
  typedef struct packed {
    logic load;     // capture a legal instruction, step <= 0
    logic advance;  // step <= step + 1
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seqState_t;

  localparam int MUL_CODE_W = 3;
endpackage

// File: rtl/vrgDecode.sv
module vrgDecode #(
  parameter int IDX_W   = 5,
  parameter int MAX_LOG = 3,
  localparam int STEP_W = MAX_LOG,
  localparam int LOG_W  = $clog2(MAX_LOG + 2)
) (
  input  logic [IDX_W-1:0]                 dstIdx,
  input  logic [IDX_W-1:0]                 srcAIdx,
  input  logic [IDX_W-1:0]                 srcBIdx,
  input  logic                             widen,
  input  logic [vrgPkg::MUL_CODE_W-1:0]    mulCode,
  output logic                             badInstr,
  output logic                             wideEff,
  output logic [STEP_W-1:0]                lastStep
);
  logic isFrac, isReserved, tooWide;
  logic [LOG_W-1:0] grpLog, effLog;
  logic [STEP_W:0]  grpCnt;

  function automatic logic misaligned(input logic [IDX_W-1:0] idx,
                                      input logic [LOG_W-1:0] lg);
    logic [IDX_W-1:0] lowMask;
    lowMask = (IDX_W'(1) << lg) - IDX_W'(1);
    return |(idx & lowMask);
  endfunction

  always_comb begin
    isReserved = (mulCode == 3'b100);
    isFrac     = mulCode[2] && (mulCode[1:0] != 2'b00);
    grpLog     = (isReserved || isFrac) ? '0 : LOG_W'(mulCode[1:0]);
    wideEff    = widen && !isFrac;
    effLog     = grpLog + LOG_W'(wideEff);
    tooWide    = effLog > LOG_W'(MAX_LOG);
    badInstr   = isReserved || tooWide
              || misaligned(dstIdx, effLog)
              || misaligned(srcAIdx, effLog)
              || misaligned(srcBIdx, grpLog);
    grpCnt     = (STEP_W+1)'(1) << effLog;
    lastStep   = STEP_W'(grpCnt - (STEP_W+1)'(1));
  end
endmodule

// File: rtl/vrgCtrl.sv
module vrgCtrl
  import vrgPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       badInstr,
  input  logic       uopReady,
  input  logic       isLast,
  output logic       inReady,
  output logic       illegal,
  output logic       uopValid,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;

  always_comb begin
    inReady        = (state == SEQ_IDLE);
    uopValid       = (state == SEQ_ISSUE);
    illegal        = inValid && inReady && badInstr;
    strobe.load    = inValid && inReady && !badInstr;
    strobe.advance = uopValid && uopReady && !isLast;
    stateNext      = state;
    if (strobe.load)                       stateNext = SEQ_ISSUE;
    else if (uopValid && uopReady && isLast) stateNext = SEQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= stateNext;
  end
endmodule

// File: rtl/vrgDatapath.sv
module vrgDatapath
  import vrgPkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int MAX_LOG = 3,
  localparam int STEP_W = MAX_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  inDst,
  input  logic [IDX_W-1:0]  inSrcA,
  input  logic [IDX_W-1:0]  inSrcB,
  input  logic              wideEff,
  input  logic [STEP_W-1:0] lastStepIn,
  output logic [IDX_W-1:0]  uopDst,
  output logic [IDX_W-1:0]  uopSrcA,
  output logic [IDX_W-1:0]  uopSrcB,
  output logic              uopHalf,
  output logic              isLast
);
  logic [IDX_W-1:0]  baseDst, baseA, baseB;
  logic              wideQ;
  logic [STEP_W-1:0] lastQ, step;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseDst <= '0;
      baseA   <= '0;
      baseB   <= '0;
      wideQ   <= 1'b0;
      lastQ   <= '0;
      step    <= '0;
    end else if (strobe.load) begin
      baseDst <= inDst;
      baseA   <= inSrcA;
      baseB   <= inSrcB;
      wideQ   <= wideEff;
      lastQ   <= lastStepIn;
      step    <= '0;
    end else if (strobe.advance) begin
      step    <= step + STEP_W'(1);
    end
  end

  always_comb begin
    uopDst  = baseDst + IDX_W'(step);
    uopSrcA = baseA + IDX_W'(step);
    uopSrcB = wideQ ? baseB + IDX_W'(step >> 1) : baseB + IDX_W'(step);
    uopHalf = wideQ && step[0];
    isLast  = (step == lastQ);
  end
endmodule

// File: rtl/vrgSeq.sv
module vrgSeq
  import vrgPkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [IDX_W-1:0] inDst,
  input  logic [IDX_W-1:0] inSrcA,
  input  logic [IDX_W-1:0] inSrcB,
  input  logic             inWiden,
  input  logic [2:0]       inMulCode,
  output logic             illegal,
  output logic             uopValid,
  input  logic             uopReady,
  output logic [IDX_W-1:0] uopDst,
  output logic [IDX_W-1:0] uopSrcA,
  output logic [IDX_W-1:0] uopSrcB,
  output logic             uopHalf,
  output logic             uopLast
);
  localparam int STEP_W = MAX_LOG;

  seqStrobe_t        strobe;
  logic              badInstr, wideEff, isLast;
  logic [STEP_W-1:0] lastStep;

  vrgDecode #(.IDX_W(IDX_W), .MAX_LOG(MAX_LOG)) u_dec (
    .dstIdx(inDst), .srcAIdx(inSrcA), .srcBIdx(inSrcB),
    .widen(inWiden), .mulCode(inMulCode),
    .badInstr(badInstr), .wideEff(wideEff), .lastStep(lastStep)
  );

  vrgCtrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .badInstr(badInstr),
    .uopReady(uopReady), .isLast(isLast), .inReady(inReady),
    .illegal(illegal), .uopValid(uopValid), .strobe(strobe)
  );

  vrgDatapath #(.IDX_W(IDX_W), .MAX_LOG(MAX_LOG)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .wideEff(wideEff), .lastStepIn(lastStep),
    .uopDst(uopDst), .uopSrcA(uopSrcA), .uopSrcB(uopSrcB),
    .uopHalf(uopHalf), .isLast(isLast)
  );

  assign uopLast = uopValid && isLast;
endmodule

// File: rtl/vrgSeqChecker.sv
module vrgSeqChecker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic [2:0]       inMulCode,
  input logic             illegal,
  input logic             uopValid,
  input logic             uopReady,
  input logic [IDX_W-1:0] uopDst,
  input logic [IDX_W-1:0] uopSrcA,
  input logic [IDX_W-1:0] uopSrcB,
  input logic             uopHalf,
  input logic             uopLast
);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    uopValid |-> !inReady);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
    uopValid && uopReady && uopLast |=> !uopValid && inReady);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    uopValid && !uopReady |=> uopValid && $stable(uopDst) && $stable(uopSrcA)
      && $stable(uopSrcB) && $stable(uopHalf) && $stable(uopLast));

  p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
    uopValid && uopReady && !uopLast |=> uopValid
      && uopDst == $past(uopDst) + IDX_W'(1)
      && uopSrcA == $past(uopSrcA) + IDX_W'(1));

  p_illegal_accept_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> inValid && inReady);

  p_illegal_silent_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !uopValid);

  p_half_odd_r5: assert property (@(posedge clk) disable iff (rst)
    uopValid && uopHalf |-> uopDst[0]);

  p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && inMulCode == 3'b100 |-> illegal);
endmodule

bind vrgSeq vrgSeqChecker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .inMulCode(inMulCode), .illegal(illegal), .uopValid(uopValid),
  .uopReady(uopReady), .uopDst(uopDst), .uopSrcA(uopSrcA),
  .uopSrcB(uopSrcB), .uopHalf(uopHalf), .uopLast(uopLast)
);

// File: tb/vrgSeq_tb.sv
`timescale 1ns/1ps
module vrgSeq_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       inValid, inReady, inWiden, illegal;
  logic [4:0] inDst, inSrcA, inSrcB;
  logic [2:0] inMulCode;
  logic       uopValid, uopReady, uopHalf, uopLast;
  logic [4:0] uopDst, uopSrcA, uopSrcB;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vrgSeq u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB), .inWiden(inWiden),
    .inMulCode(inMulCode), .illegal(illegal), .uopValid(uopValid),
    .uopReady(uopReady), .uopDst(uopDst), .uopSrcA(uopSrcA),
    .uopSrcB(uopSrcB), .uopHalf(uopHalf), .uopLast(uopLast)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model from the requirements
  function automatic bit isFracCode(input int code);
    return code >= 5;
  endfunction
  function automatic int effLogOf(input bit w, input int code);
    int l;
    l = (code >= 4) ? 0 : code;
    return (w && !isFracCode(code)) ? l + 1 : l;
  endfunction
  function automatic bit expIllegal(input int d, input int a, input int b,
                                    input bit w, input int code);
    int el, nl;
    if (code == 4) return 1;                  // R7
    el = effLogOf(w, code);
    nl = (code >= 4) ? 0 : code;
    if (el > 3) return 1;                     // R6
    if (d % (1 << el) != 0) return 1;         // R3
    if (a % (1 << el) != 0) return 1;
    if (b % (1 << nl) != 0) return 1;
    return 0;
  endfunction
  function automatic string illTag(input bit w, input int code);
    if (code == 4) return "R7";
    if (w && code == 3) return "R6";
    return "R3";
  endfunction

  task automatic idleInputs();
    inValid = 0; inDst = 0; inSrcA = 0; inSrcB = 0; inWiden = 0; inMulCode = 0;
  endtask

  // Starts and ends at a negedge
  task automatic runInstr(input int d, input int a, input int b, input bit w,
                          input int code, input int readyPct, input bit noise);
    bit ill, wide, stalled;
    int n, k;
    string seqTag;
    inValid = 1; inDst = 5'(d); inSrcA = 5'(a); inSrcB = 5'(b);
    inWiden = w; inMulCode = 3'(code); uopReady = 0;
    ill = expIllegal(d, a, b, w, code);
    #1;
    chk(inReady == 1'b1, "R8 ready when idle", int'(inReady), 1);
    chk(illegal == ill, ill ? illTag(w, code) : "R9 legal no flag", int'(illegal), int'(ill));
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    if (ill) begin
      #1;
      chk(uopValid == 1'b0, "R9 no uop after illegal", int'(uopValid), 0);
      chk(illegal == 1'b0, "R9 flag one cycle", int'(illegal), 0);
      return;
    end
    wide = w && !isFracCode(code);
    n = 1 << effLogOf(w, code);
    seqTag = isFracCode(code) ? "R2" : (wide ? "R5" : "R1");
    k = 0;
    stalled = 0;
    while (k < n) begin
      if (noise) begin
        inValid = 1'($urandom); inDst = 5'($urandom); inSrcA = 5'($urandom);
        inSrcB = 5'($urandom); inWiden = 1'($urandom); inMulCode = 3'($urandom);
      end
      uopReady = (($urandom % 100) < readyPct);
      #1;
      chk(uopValid == 1'b1, stalled ? "R11 valid held" : seqTag, int'(uopValid), 1);
      chk(int'(uopDst) == d + k, stalled ? "R11 dst held" : (wide ? "R5 dst" : "R4 dst"),
          int'(uopDst), d + k);
      chk(int'(uopSrcA) == a + k, wide ? "R5 srcA" : "R4 srcA", int'(uopSrcA), a + k);
      chk(int'(uopSrcB) == (wide ? b + k / 2 : b + k), wide ? "R5 srcB" : "R4 srcB",
          int'(uopSrcB), wide ? b + k / 2 : b + k);
      chk(uopHalf == (wide ? k % 2 : 0), wide ? "R5 half" : "R2 half",
          int'(uopHalf), wide ? k % 2 : 0);
      chk(uopLast == (k == n - 1), seqTag, int'(uopLast), int'(k == n - 1));
      chk(inReady == 1'b0 && illegal == 1'b0, "R8 busy ignores input",
          int'(inReady), 0);
      stalled = !uopReady;
      @(posedge clk);
      if (uopReady) k++;
      @(negedge clk);
    end
    idleInputs();
    uopReady = 0;
    #1;
    chk(uopValid == 1'b0 && inReady == 1'b1, "R8 idle after last",
        int'(uopValid), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; uopReady = 0;
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(uopValid == 0 && inReady == 1 && illegal == 0, "R10 reset idle", int'(uopValid), 0);
    rst = 0;
    @(negedge clk);

    // Directed corner cases
    runInstr(16, 8, 24, 0, 3, 100, 0);   // R1, R4 group of 8
    runInstr(16, 8, 24, 0, 3, 40, 1);    // R11 stalls, R8 noise
    runInstr(8, 16, 4, 1, 2, 70, 0);     // R5 widen 4 -> 8
    runInstr(2, 6, 1, 1, 0, 100, 0);     // R5 widen 1 -> 2
    runInstr(8, 16, 8, 1, 3, 100, 0);    // R6 illegal
    runInstr(0, 0, 0, 0, 4, 100, 0);     // R7 reserved
    runInstr(5, 6, 6, 0, 1, 100, 0);     // R3 misaligned dst
    runInstr(4, 4, 6, 0, 2, 100, 0);     // R3 misaligned srcB
    runInstr(2, 4, 2, 1, 2, 100, 0);     // R3 wide srcA of 4 -> needs 8
    runInstr(5, 3, 7, 0, 7, 100, 0);     // R2 fractional
    runInstr(3, 9, 1, 1, 5, 100, 0);     // R2 fractional widening
    runInstr(31, 31, 31, 0, 0, 100, 0);  // R1 group of 1 at top index

    // R10: reset in the middle of a sequence
    inValid = 1; inDst = 5'd0; inSrcA = 5'd8; inSrcB = 5'd16; inWiden = 0;
    inMulCode = 3'd3; uopReady = 1;
    @(posedge clk); @(negedge clk);
    idleInputs();
    @(posedge clk); @(negedge clk);
    rst = 1; uopReady = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    #1;
    chk(uopValid == 0 && inReady == 1, "R10 reset mid-sequence", int'(uopValid), 0);
    @(negedge clk);

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      int d, a, b, code;
      bit w;
      code = $urandom % 8;
      w    = 1'($urandom);
      d = (($urandom % 10) < 7) ? ($urandom % 4) * 8 : $urandom % 32;
      a = (($urandom % 10) < 7) ? ($urandom % 4) * 8 : $urandom % 32;
      b = (($urandom % 10) < 7) ? ($urandom % 8) * 4 : $urandom % 32;
      runInstr(d, a, b, w, code, 30 + $urandom % 71, 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule